// File: doc/BRIEF.md
# Reset and Output Mute Sequencer

This block is the control state machine that sits beside a sample-stream converter and decides when converted samples may reach the serial output. It holds the converter core in reset while the active-low power-down input is low. After release it waits for the core to report both clock lock and a detected sample rate, and only then lets real samples through. Until then, and whenever it is not in normal operation, the output word is forced to zero.

The length of each power-down pulse is measured on a reference tick. A short pulse gives the lock phase a tight time budget and a long pulse gives a relaxed one. If the budget runs out before lock and rate detection are both seen, a sticky timeout flag is raised and the output stays muted until the next power-down. While running, the block watches an input-clock activity strobe. If the strobe goes quiet for a set number of ticks, the block mutes, waits for the clock to come back, and then goes through lock and rate detection again. The valid flag rises only on a sample boundary, so a partial word is never marked valid.

Top module: `stream_mute_seq`

## Requirements
- R1: While `rst` is high and on the first edge after it, `core_rst` is 1, `dout` is 0, `dout_valid` is 0 and `lock_timeout` is 0.
- R2: After `rst`, the block stays in power-down (`core_rst` = 1, output muted) until `pwrdn_n` has been sampled low at least once, whatever the other inputs do.
- R3: On the first edge that samples `pwrdn_n` low, from any state, `core_rst` becomes 1, `dout` becomes 0, and both `dout_valid` and `lock_timeout` become 0.
- R4: The edge that samples `pwrdn_n` high after a low period enters the lock phase and drops `core_rst`. In that phase `dout` stays 0 until an edge samples `core_locked` and `rate_found` both high, which enters normal operation.
- R5: `dout_valid` rises on the first edge, after the entry edge into normal operation, that samples `smp_bound` high. From then on, each edge loads `smp_data` into `dout`. While `dout_valid` is 0, `dout` is 0.
- R6: The number N of ticks during which `pwrdn_n` was low is measured. N ≤ SHORT_RST_TICKS selects the budget BUDGET_SHORT, and a larger N selects BUDGET_LONG.
- R7: If the lock phase has not ended when the selected budget B expires, `lock_timeout` rises on the (B+1)th edge after the release edge (with a tick every cycle). The output then stays muted even if lock and rate detection arrive later, and this lasts until the next power-down.
- R8: In normal operation, once `in_clk_act` has been low for LOSS_TICKS ticks, the next edge clears `dout_valid` and zeroes `dout`.
- R9: After a clock loss, the output stays muted until an `in_clk_act` strobe has been seen and then `core_locked` and `rate_found` are both sampled high. A fresh `smp_bound` is needed before `dout_valid` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference tick enable for all timers |
| pwrdn_n | input | 1 | Active-low power-down request |
| in_clk_act | input | 1 | One-cycle strobe per input-port clock edge seen |
| core_locked | input | 1 | Converter core reports clock lock |
| rate_found | input | 1 | Converter core reports a detected sample rate |
| smp_data | input | DATA_W | Converted sample word |
| smp_bound | input | 1 | Marks the first cycle of a sample word |
| core_rst | output | 1 | Holds the converter core in its initial state |
| dout | output | DATA_W | Gated sample output, zero when muted |
| dout_valid | output | 1 | Output word is real data |
| lock_timeout | output | 1 | Lock phase exceeded its budget (sticky until power-down) |

## Verification
Every output is a register loaded from the next-state decode. A change on `pwrdn_n`, the lock inputs or `smp_bound` therefore shows up exactly one edge after it is sampled. The bench drives inputs just after a rising edge and reads outputs one edge later. With the tick held high, the budget timeout falls exactly on the (B+1)th edge after release. The bench checks that the flag is still low one edge earlier, and it distinguishes N = SHORT_RST_TICKS from N = SHORT_RST_TICKS+1. Clock loss depends on when the last strobe fell relative to the stop request, which leaves an uncertainty of one edge. The bench therefore checks that `dout_valid` is still high after LOSS_TICKS-1 edges and low after LOSS_TICKS+1 edges.

// File: rtl/mute_seq_pkg.sv
package mute_seq_pkg;
  typedef enum logic [2:0] {
    ST_PD,
    ST_LOCK,
    ST_RUN,
    ST_UNLOCK,
    ST_TOUT
  } seq_state_t;
endpackage

// File: rtl/pd_width_meter.sv
module pd_width_meter #(
  parameter int SHORT_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pwrdn_n,
  output logic long_o
);
  localparam int CNT_W = $clog2(SHORT_TICKS + 2);
  localparam logic [CNT_W-1:0] SAT_V   = CNT_W'(SHORT_TICKS + 1);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             low_q;
  logic             long_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      low_q  <= 1'b0;
      long_q <= 1'b0;
    end else begin
      low_q <= ~pwrdn_n;
      if (!pwrdn_n) begin
        if (tick && cnt_q != SAT_V) cnt_q <= cnt_q + 1'b1;
      end else if (low_q) begin
        long_q <= (cnt_q > SHORT_V);
        cnt_q  <= '0;
      end
    end
  end

  assign long_o = long_q;

  // R6: the latched budget selector only moves on a release edge
  assert_long_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !low_q |=> $stable(long_q));
endmodule

// File: rtl/budget_timer.sv
module budget_timer #(
  parameter int BUDGET_SHORT = 100,
  parameter int BUDGET_LONG  = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run_en,
  input  logic long_sel,
  output logic expired_o
);
  localparam int CNT_W = $clog2(BUDGET_LONG + 1);
  localparam logic [CNT_W-1:0] LIM_S = CNT_W'(BUDGET_SHORT);
  localparam logic [CNT_W-1:0] LIM_L = CNT_W'(BUDGET_LONG);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit     = long_sel ? LIM_L : LIM_S;
  assign expired_o = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run_en) cnt_q <= '0;
    else if (tick && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  // R7: the watchdog never counts past the larger budget
  assert_budget_cap_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM_L);
endmodule

// File: rtl/clk_loss_mon.sv
module clk_loss_mon #(
  parameter int LOSS_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  input  logic edge_i,
  output logic lost_o
);
  localparam int CNT_W = $clog2(LOSS_TICKS + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LOSS_TICKS);

  logic [CNT_W-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst || clear || edge_i) idle_q <= '0;
    else if (tick && idle_q != LIM) idle_q <= idle_q + 1'b1;
  end

  assign lost_o = (idle_q == LIM);

  // R8: a clock strobe always restarts the silence count
  assert_edge_restart_R8: assert property (@(posedge clk) disable iff (rst)
    edge_i |=> !lost_o);
endmodule

// File: rtl/stream_mute_seq.sv
module stream_mute_seq
  import mute_seq_pkg::*;
#(
  parameter int DATA_W          = 24,
  parameter int SHORT_RST_TICKS = 10,
  parameter int BUDGET_SHORT    = 100,
  parameter int BUDGET_LONG     = 200,
  parameter int LOSS_TICKS      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              pwrdn_n,
  input  logic              in_clk_act,
  input  logic              core_locked,
  input  logic              rate_found,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_bound,
  output logic              core_rst,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  output logic              lock_timeout
);
  seq_state_t state_q, nxt;
  logic       armed_q;
  logic       long_rst;
  logic       expired;
  logic       clk_lost;
  logic       valid_nxt;

  pd_width_meter #(.SHORT_TICKS(SHORT_RST_TICKS)) u_meter (
    .clk(clk), .rst(rst), .tick(tick), .pwrdn_n(pwrdn_n), .long_o(long_rst));

  budget_timer #(.BUDGET_SHORT(BUDGET_SHORT), .BUDGET_LONG(BUDGET_LONG)) u_budget (
    .clk(clk), .rst(rst), .tick(tick), .run_en(state_q == ST_LOCK),
    .long_sel(long_rst), .expired_o(expired));

  clk_loss_mon #(.LOSS_TICKS(LOSS_TICKS)) u_loss (
    .clk(clk), .rst(rst), .tick(tick), .clear(state_q == ST_PD),
    .edge_i(in_clk_act), .lost_o(clk_lost));

  always_comb begin
    nxt = state_q;
    if (!pwrdn_n) nxt = ST_PD;
    else begin
      unique case (state_q)
        ST_PD:     if (armed_q) nxt = ST_LOCK;
        ST_LOCK:   if (core_locked && rate_found) nxt = ST_RUN;
                   else if (expired) nxt = ST_TOUT;
        ST_RUN:    if (clk_lost) nxt = ST_UNLOCK;
        ST_UNLOCK: if (in_clk_act) nxt = ST_LOCK;
        ST_TOUT:   nxt = ST_TOUT;
        default:   nxt = ST_PD;
      endcase
    end
  end

  assign valid_nxt = (nxt == ST_RUN) && (state_q == ST_RUN) && (dout_valid || smp_bound);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_PD;
      armed_q      <= 1'b0;
      core_rst     <= 1'b1;
      dout         <= '0;
      dout_valid   <= 1'b0;
      lock_timeout <= 1'b0;
    end else begin
      state_q      <= nxt;
      if (!pwrdn_n) armed_q <= 1'b1;
      core_rst     <= (nxt == ST_PD);
      dout_valid   <= valid_nxt;
      dout         <= valid_nxt ? smp_data : '0;
      lock_timeout <= (nxt == ST_TOUT);
    end
  end

  // R2: no exit from power-down before a power-down pulse
  assert_unarmed_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> core_rst);
  // R3: power-down request mutes and resets on the next edge
  assert_pd_mute_R3: assert property (@(posedge clk) disable iff (rst)
    !pwrdn_n |=> (core_rst && !dout_valid && !lock_timeout && dout == '0));
  // R5: no data leaks while the word is not valid
  assert_quiet_invalid_R5: assert property (@(posedge clk) disable iff (rst)
    !dout_valid |-> dout == '0);
  // R7: timeout keeps the output muted
  assert_timeout_mute_R7: assert property (@(posedge clk) disable iff (rst)
    lock_timeout |-> !dout_valid);
  // R8: a lost input clock drops valid on the next edge
  assert_loss_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && clk_lost) |=> !dout_valid);
endmodule

// File: tb/test_stream_mute_seq.sv
module test_stream_mute_seq;
  localparam int DW = 16;
  localparam int SHORT_T = 10;
  localparam int B_S = 20;
  localparam int B_L = 40;
  localparam int LOSS = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic pwrdn_n = 1'b1;
  logic clk_on = 1'b0;
  logic ph = 1'b0;
  logic in_clk_act;
  logic core_locked = 1'b0;
  logic rate_found = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic smp_bound = 1'b0;
  logic core_rst, dout_valid, lock_timeout;
  logic [DW-1:0] dout;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(negedge clk) ph <= ~ph;
  assign in_clk_act = clk_on & ph;

  stream_mute_seq #(.DATA_W(DW), .SHORT_RST_TICKS(SHORT_T), .BUDGET_SHORT(B_S),
    .BUDGET_LONG(B_L), .LOSS_TICKS(LOSS)) i_stream_mute_seq (
    .clk(clk), .rst(rst), .tick(tick), .pwrdn_n(pwrdn_n), .in_clk_act(in_clk_act),
    .core_locked(core_locked), .rate_found(rate_found), .smp_data(smp_data),
    .smp_bound(smp_bound), .core_rst(core_rst), .dout(dout), .dout_valid(dout_valid),
    .lock_timeout(lock_timeout));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      summary();
    end
  end

  // Pulse power-down low for n edges, then release with one edge
  task automatic pd_pulse(input int n);
    pwrdn_n = 1'b0;
    step();
    chk(core_rst && !dout_valid && dout == '0 && !lock_timeout, "R3 pd mute",
        {core_rst, dout_valid, lock_timeout}, 32'h4);
    for (int i = 1; i < n; i++) step();
    pwrdn_n = 1'b1;
    step();
    chk(!core_rst, "R4 release drops core_rst", core_rst, 0);
  endtask

  task automatic t_reset();
    bit ok = 1'b1;
    rst = 1'b1; pwrdn_n = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk(core_rst && dout == '0 && !dout_valid && !lock_timeout, "R1 reset state",
        {core_rst, dout_valid, lock_timeout}, 32'h4);
    core_locked = 1'b1; rate_found = 1'b1; clk_on = 1'b1; smp_data = 16'hbeef;
    for (int i = 0; i < 30; i++) begin
      smp_bound = (i % 4 == 0);
      step();
      if (!core_rst || dout_valid || dout != '0) ok = 1'b0;
    end
    smp_bound = 1'b0;
    chk(ok, "R2 no exit without pd pulse", {core_rst, dout_valid}, 32'h2);
  endtask

  task automatic t_normal();
    core_locked = 1'b0; rate_found = 1'b0; clk_on = 1'b1;
    pd_pulse(5);
    smp_data = 16'h00a5; smp_bound = 1'b1;
    repeat (3) step();
    chk(dout == '0 && !dout_valid, "R4 muted during lock phase", dout, 0);
    core_locked = 1'b1; smp_bound = 1'b0;
    step();
    chk(dout == '0 && !dout_valid, "R4 lock alone not enough", dout, 0);
    rate_found = 1'b1;
    step();
    chk(!dout_valid, "R5 no valid without boundary", dout_valid, 0);
    smp_data = 16'h0123;
    step();
    chk(!dout_valid && dout == '0, "R5 still muted before boundary", dout, 0);
    smp_bound = 1'b1; smp_data = 16'h1234;
    step();
    chk(dout_valid && dout == 16'h1234, "R5 first word on boundary", dout, 32'h1234);
    smp_bound = 1'b0; smp_data = 16'h4321;
    step();
    chk(dout_valid && dout == 16'h4321, "R5 data follows", dout, 32'h4321);
  endtask

  task automatic t_loss();
    clk_on = 1'b0;
    for (int i = 0; i < LOSS - 1; i++) step();
    chk(dout_valid, "R8 valid held before loss limit", dout_valid, 1);
    repeat (2) step();
    chk(!dout_valid && dout == '0, "R8 loss mutes", dout_valid, 0);
    core_locked = 1'b0;
    repeat (10) step();
    chk(!dout_valid && dout == '0, "R9 stays muted without clock", dout_valid, 0);
    clk_on = 1'b1;
    repeat (5) step();
    chk(!dout_valid, "R9 muted until relock", dout_valid, 0);
    core_locked = 1'b1;
    repeat (2) step();
    chk(!dout_valid, "R9 needs fresh boundary", dout_valid, 0);
    smp_bound = 1'b1; smp_data = 16'h7777;
    step();
    smp_bound = 1'b0;
    chk(dout_valid && dout == 16'h7777, "R9 recovered", dout, 32'h7777);
  endtask

  task automatic t_pd_in_run();
    pwrdn_n = 1'b0;
    step();
    chk(core_rst && !dout_valid && dout == '0, "R3 pd from run", {core_rst, dout_valid}, 32'h2);
    pwrdn_n = 1'b1;
    step();
  endtask

  task automatic t_timeout(input int n, input int budget);
    bit ok = 1'b1;
    core_locked = 1'b0; rate_found = 1'b0;
    pd_pulse(n);
    for (int i = 0; i < budget; i++) begin
      step();
      if (lock_timeout) ok = 1'b0;
    end
    chk(ok, "R6 no timeout inside budget", lock_timeout, 0);
    step();
    chk(lock_timeout, "R7 timeout at budget end", lock_timeout, 1);
    core_locked = 1'b1; rate_found = 1'b1; smp_bound = 1'b1; smp_data = 16'h5a5a;
    repeat (5) step();
    smp_bound = 1'b0;
    chk(lock_timeout && !dout_valid && dout == '0, "R7 timeout stays muted",
        {lock_timeout, dout_valid}, 32'h2);
    pwrdn_n = 1'b0;
    step();
    chk(!lock_timeout && core_rst, "R3 pd clears timeout", lock_timeout, 0);
    pwrdn_n = 1'b1;
    step();
  endtask

  initial begin
    t_reset();
    t_normal();
    t_loss();
    t_pd_in_run();
    t_timeout(SHORT_T, B_S);
    t_timeout(SHORT_T + 1, B_L);
    t_timeout(3, B_S);
    summary();
  end
endmodule